// File: doc/BRIEF.md
# Capture Gating and Output Steering Controller

This block sits between the input pins and internal event sources of a timer-based capture/compare channel and the channel's capture unit. It picks one of eight candidate capture sources, turns a rising edge on the chosen source into a single-clock capture event, and passes that event on only when a gating policy allows it. The policy is either level-sensitive, which follows a gate signal, or one-shot. In a one-shot mode, an edge on the gate signal arms or disarms a sticky disable flag.

The block also drives an auxiliary output. This output can report time-base rollovers, follow a signal defined by the operating mode, or report capture and compare events. It decides when a new output-enable value takes effect: either on the next clock, or held in a shadow register until the next time-base reset or rollover. It also tells the pin multiplexer whether the channel owns the output pin.

All control fields come from an external register bank and are zero after reset.

Top module: `capgate_ctrl`

## Requirements
- R1: While reset is asserted and on release, `cap_evt`, `aux_out`, `oe_eff`, `cap_dis` and `pin_out` are 0.
- R2: `src_sel` picks bit `src_in[src_sel]`. Code 0 is the dedicated capture pin, codes 1 to 3 are comparators 1 to 3, and codes 4 to 7 are logic-cell outputs 1 to 4. A rising edge on the selected bit, seen at a clock edge, gives a one-cycle `cap_evt` pulse in the following cycle when the gate allows it. Edges on sources that are not selected give nothing.
- R3: With `gate_mode` = 00 (level), a capture passes only if `gate_in` was 1 at the clock edge before the source edge. If it was 0, the capture is blocked.
- R4: With `gate_mode` = 01, a rising edge on `gate_in` clears `cap_dis` one cycle later. Captures pass while `cap_dis` = 0. A falling edge has no effect in this mode.
- R5: With `gate_mode` = 10, a falling edge on `gate_in` sets `cap_dis`, and captures are blocked while it is 1. A rising edge has no effect in this mode. `cap_dis` holds its value otherwise. A write (`dis_wr`) loads `dis_wdata` into it, and the write wins over a gate edge in the same cycle.
- R6: With `gate_mode` = 11 (reserved), no capture event is produced.
- R7: With `aux_sel` = 00, `aux_out` stays 0. With `aux_sel` = 01, `aux_out` follows `tbase_roll` one cycle later, in every mode.
- R8: With `aux_sel` = 10, `aux_out` follows `mode_sig` one cycle later. With `aux_sel` = 11, it pulses one cycle after a forwarded capture or a `cmp_evt`, and stays 0 while `timer_mode` = 1.
- R9: With `oe_sync` = 0, a write (`oe_wr`) sets `oe_eff` to `oe_wdata` on the next cycle.
- R10: With `oe_sync` = 1, a write is held in a shadow register, and a later write replaces it. The shadow value is applied on the clock where `tbase_roll` or `tbase_rst` is high, and is visible in the next cycle. A write in that same clock is applied directly. Without such a strobe, `oe_eff` does not change.
- R11: `pin_own` equals `steer`. `pin_out` is `cmp_out` AND `oe_eff` while `steer` = 1, and 0 while `steer` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Candidate capture sources |
| src_sel | input | SEL_W | Capture source select |
| gate_in | input | 1 | Gating source |
| gate_mode | input | 2 | Gating policy (00 level, 01 arm on rise, 10 disarm on fall, 11 reserved) |
| dis_wr | input | 1 | Write strobe for the sticky disable flag |
| dis_wdata | input | 1 | Value written to the disable flag |
| aux_sel | input | 2 | Auxiliary output selection |
| tbase_roll | input | 1 | Time-base rollover strobe |
| tbase_rst | input | 1 | Time-base reset strobe |
| cmp_evt | input | 1 | Compare event strobe |
| mode_sig | input | 1 | Signal defined by the operating mode |
| timer_mode | input | 1 | High when the channel is in plain timer mode |
| oe_sync | input | 1 | 1 defers output-enable writes to a time-base boundary |
| oe_wr | input | 1 | Output-enable write strobe |
| oe_wdata | input | 1 | Output-enable value written |
| steer | input | 1 | 1 gives the pin to the channel |
| cmp_out | input | 1 | Compare/PWM waveform |
| cap_evt | output | 1 | Qualified capture event pulse |
| cap_dis | output | 1 | Sticky one-shot capture disable flag |
| aux_out | output | 1 | Auxiliary output |
| oe_eff | output | 1 | Output enable currently in force |
| pin_own | output | 1 | Channel owns the output pin |
| pin_out | output | 1 | Value driven onto the pin |

## Verification
The assertions check on every cycle the rules that hold whatever the history:
- the reserved gating code blocks captures;
- a low gate blocks captures in level mode;
- the disable flag holds without an edge or a write;
- the output enable stays frozen in deferred mode until a boundary strobe;
- an immediate write lands one cycle later;
- a disabled auxiliary output stays low, and a rollover reaches it when it is selected;
- a released pin stays low.

Only the bench scenarios can show the behaviours that depend on a sequence: arming and disarming across several cycles, a later deferred write replacing an earlier one, software writes winning over gate edges, and the exact number of capture events that each source select produces. The bench's cycle model also compares every output under long stretches of random stimulus.

// File: rtl/capgate_pkg.sv
package capgate_pkg;

  typedef enum logic [1:0] {
    GM_LEVEL       = 2'b00,
    GM_ARM_RISE    = 2'b01,
    GM_DISARM_FALL = 2'b10,
    GM_RSVD        = 2'b11
  } gate_mode_e;

  typedef enum logic [1:0] {
    AX_OFF   = 2'b00,
    AX_ROLL  = 2'b01,
    AX_MODE  = 2'b10,
    AX_EVENT = 2'b11
  } aux_sel_e;

  // Whether the gate policy lets a capture through this cycle.
  function automatic logic gate_allows(gate_mode_e m, logic lvl_q, logic dis_q);
    logic ok;
    case (m)
      GM_LEVEL:       ok = lvl_q;
      GM_ARM_RISE,
      GM_DISARM_FALL: ok = ~dis_q;
      default:        ok = 1'b0;
    endcase
    return ok;
  endfunction

  // Next value of the sticky disable flag; software write has priority.
  function automatic logic next_dis(gate_mode_e m, logic wr, logic wdata,
                                    logic rise, logic fall, logic cur);
    logic nx;
    nx = cur;
    if (wr)                              nx = wdata;
    else if (m == GM_ARM_RISE && rise)   nx = 1'b0;
    else if (m == GM_DISARM_FALL && fall) nx = 1'b1;
    return nx;
  endfunction

  // Auxiliary output selection.
  function automatic logic aux_pick(aux_sel_e s, logic roll, logic msig,
                                    logic evt, logic tmr);
    logic o;
    case (s)
      AX_ROLL:  o = roll;
      AX_MODE:  o = msig;
      AX_EVENT: o = evt & ~tmr;
      default:  o = 1'b0;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/capgate_src_edge.sv
module capgate_src_edge #(
  parameter int NUM_SRC = 8,
  localparam int SEL_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [SEL_W-1:0]   src_sel,
  output logic               sel_rise
);
  logic [NUM_SRC-1:0] prev_q;
  logic [NUM_SRC-1:0] rise_vec;

  // Every source keeps its own history so a select change cannot fake an edge.
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= src_in[g];
    end
    assign rise_vec[g] = src_in[g] & ~prev_q[g];
  end

  assign sel_rise = rise_vec[src_sel];
endmodule

// File: rtl/capgate_gate.sv
module capgate_gate
  import capgate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gate_in,
  input  logic [1:0] gate_mode,
  input  logic       dis_wr,
  input  logic       dis_wdata,
  output logic       gate_ok,
  output logic       gate_rise,
  output logic       gate_fall,
  output logic       dis_q
);
  logic       gate_q;
  gate_mode_e mode;

  assign mode      = gate_mode_e'(gate_mode);
  assign gate_rise = gate_in & ~gate_q;
  assign gate_fall = ~gate_in & gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      dis_q  <= 1'b0;
    end else begin
      gate_q <= gate_in;
      dis_q  <= next_dis(mode, dis_wr, dis_wdata, gate_rise, gate_fall, dis_q);
    end
  end

  assign gate_ok = gate_allows(mode, gate_q, dis_q);
endmodule

// File: rtl/capgate_oe.sv
module capgate_oe (
  input  logic clk,
  input  logic rst_n,
  input  logic oe_sync,
  input  logic oe_wr,
  input  logic oe_wdata,
  input  logic bound,
  output logic oe_eff
);
  logic shadow_q;
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_eff   <= 1'b0;
      shadow_q <= 1'b0;
      pend_q   <= 1'b0;
    end else if (oe_wr && (!oe_sync || bound)) begin
      oe_eff <= oe_wdata;
      pend_q <= 1'b0;
    end else if (oe_wr) begin
      shadow_q <= oe_wdata;
      pend_q   <= 1'b1;
    end else if (bound && pend_q) begin
      oe_eff <= shadow_q;
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/capgate_ctrl.sv
module capgate_ctrl
  import capgate_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int SEL_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [SEL_W-1:0]   src_sel,
  input  logic               gate_in,
  input  logic [1:0]         gate_mode,
  input  logic               dis_wr,
  input  logic               dis_wdata,
  input  logic [1:0]         aux_sel,
  input  logic               tbase_roll,
  input  logic               tbase_rst,
  input  logic               cmp_evt,
  input  logic               mode_sig,
  input  logic               timer_mode,
  input  logic               oe_sync,
  input  logic               oe_wr,
  input  logic               oe_wdata,
  input  logic               steer,
  input  logic               cmp_out,
  output logic               cap_evt,
  output logic               cap_dis,
  output logic               aux_out,
  output logic               oe_eff,
  output logic               pin_own,
  output logic               pin_out
);
  // Named internal events, visible to the bound checker.
  logic sel_rise_w;
  logic gate_ok_w;
  logic gate_rise_w;
  logic gate_fall_w;
  logic cap_hit_w;
  logic bound_w;

  capgate_src_edge #(.NUM_SRC(NUM_SRC)) u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_in   (src_in),
    .src_sel  (src_sel),
    .sel_rise (sel_rise_w)
  );

  capgate_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate_in   (gate_in),
    .gate_mode (gate_mode),
    .dis_wr    (dis_wr),
    .dis_wdata (dis_wdata),
    .gate_ok   (gate_ok_w),
    .gate_rise (gate_rise_w),
    .gate_fall (gate_fall_w),
    .dis_q     (cap_dis)
  );

  assign bound_w = tbase_roll | tbase_rst;

  capgate_oe u_oe (
    .clk      (clk),
    .rst_n    (rst_n),
    .oe_sync  (oe_sync),
    .oe_wr    (oe_wr),
    .oe_wdata (oe_wdata),
    .bound    (bound_w),
    .oe_eff   (oe_eff)
  );

  assign cap_hit_w = sel_rise_w & gate_ok_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_evt <= 1'b0;
      aux_out <= 1'b0;
    end else begin
      cap_evt <= cap_hit_w;
      aux_out <= aux_pick(aux_sel_e'(aux_sel), tbase_roll, mode_sig,
                          cap_hit_w | cmp_evt, timer_mode);
    end
  end

  assign pin_own = steer;
  assign pin_out = steer & oe_eff & cmp_out;
endmodule

// File: rtl/capgate_chk.sv
module capgate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] gate_mode,
  input logic       gate_in,
  input logic       dis_wr,
  input logic       gate_rise,
  input logic       gate_fall,
  input logic       cap_dis,
  input logic       cap_evt,
  input logic [1:0] aux_sel,
  input logic       tbase_roll,
  input logic       tbase_rst,
  input logic       aux_out,
  input logic       oe_sync,
  input logic       oe_wr,
  input logic       oe_wdata,
  input logic       oe_eff,
  input logic       steer,
  input logic       pin_out
);
  AST_RSVD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_mode == 2'b11) |=> !cap_evt);                                   // R6

  AST_LEVEL_LOW_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_mode == 2'b00 && !$past(gate_in)) |=> !cap_evt);               // R3

  AST_DIS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!dis_wr && !gate_rise && !gate_fall) |=> $stable(cap_dis));         // R5

  AST_OE_DEFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_sync && !tbase_roll && !tbase_rst) |=> $stable(oe_eff));         // R10

  AST_OE_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_wr && !oe_sync) |=> (oe_eff == $past(oe_wdata)));               // R9

  AST_AUX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_sel == 2'b00) |=> !aux_out);                                    // R7

  AST_AUX_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_sel == 2'b01 && tbase_roll) |=> aux_out);                       // R7

  AST_PIN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !steer |-> !pin_out);                                                // R11
endmodule

bind capgate_ctrl capgate_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .gate_mode  (gate_mode),
  .gate_in    (gate_in),
  .dis_wr     (dis_wr),
  .gate_rise  (gate_rise_w),
  .gate_fall  (gate_fall_w),
  .cap_dis    (cap_dis),
  .cap_evt    (cap_evt),
  .aux_sel    (aux_sel),
  .tbase_roll (tbase_roll),
  .tbase_rst  (tbase_rst),
  .aux_out    (aux_out),
  .oe_sync    (oe_sync),
  .oe_wr      (oe_wr),
  .oe_wdata   (oe_wdata),
  .oe_eff     (oe_eff),
  .steer      (steer),
  .pin_out    (pin_out)
);

// File: tb/sim_capgate_ctrl.sv
module sim_capgate_ctrl;
  // 20-unit period: 50 MHz with 1 ns units.
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [7:0] src_in = '0;
  logic [2:0] src_sel = '0;
  logic gate_in = 0, dis_wr = 0, dis_wdata = 0;
  logic [1:0] gate_mode = '0, aux_sel = '0;
  logic tbase_roll = 0, tbase_rst = 0, cmp_evt = 0, mode_sig = 0, timer_mode = 0;
  logic oe_sync = 0, oe_wr = 0, oe_wdata = 0, steer = 0, cmp_out = 0;
  logic cap_evt, cap_dis, aux_out, oe_eff, pin_own, pin_out;

  capgate_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .src_sel(src_sel),
    .gate_in(gate_in), .gate_mode(gate_mode), .dis_wr(dis_wr), .dis_wdata(dis_wdata),
    .aux_sel(aux_sel), .tbase_roll(tbase_roll), .tbase_rst(tbase_rst),
    .cmp_evt(cmp_evt), .mode_sig(mode_sig), .timer_mode(timer_mode),
    .oe_sync(oe_sync), .oe_wr(oe_wr), .oe_wdata(oe_wdata), .steer(steer),
    .cmp_out(cmp_out), .cap_evt(cap_evt), .cap_dis(cap_dis), .aux_out(aux_out),
    .oe_eff(oe_eff), .pin_own(pin_own), .pin_out(pin_out)
  );

  int n_chk = 0, n_fail = 0, cap_seen = 0, aux_seen = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference state.
  bit [7:0] m_prev;
  bit m_gprev, m_dis, m_oe, m_sh, m_pend, e_cap, e_aux;

  function automatic void model_step();
    bit edge_seen, pass, boundary, evt;
    edge_seen = src_in[src_sel] && !m_prev[src_sel];
    if (gate_mode == 0)      pass = m_gprev;
    else if (gate_mode == 3) pass = 0;
    else                     pass = !m_dis;
    e_cap = edge_seen && pass;
    evt = e_cap || cmp_evt;
    case (aux_sel)
      2'd1:    e_aux = tbase_roll;
      2'd2:    e_aux = mode_sig;
      2'd3:    e_aux = timer_mode ? 1'b0 : evt;
      default: e_aux = 0;
    endcase
    if (dis_wr) m_dis = dis_wdata;
    else if (gate_mode == 1 && gate_in && !m_gprev) m_dis = 0;
    else if (gate_mode == 2 && !gate_in && m_gprev) m_dis = 1;
    boundary = tbase_roll || tbase_rst;
    if (oe_wr) begin
      if (!oe_sync || boundary) begin m_oe = oe_wdata; m_pend = 0; end
      else begin m_sh = oe_wdata; m_pend = 1; end
    end else if (boundary && m_pend) begin
      m_oe = m_sh; m_pend = 0;
    end
    m_prev = src_in;
    m_gprev = gate_in;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prev = 0; m_gprev = 0; m_dis = 0; m_oe = 0; m_sh = 0; m_pend = 0;
      e_cap = 0; e_aux = 0;
    end else model_step();
    #4;
    if (rst_n && !done) begin
      chk(cap_evt === e_cap, "R2", "cap_evt", cap_evt, e_cap);
      chk(aux_out === e_aux, "R8", "aux_out", aux_out, e_aux);
      chk(cap_dis === m_dis, "R5", "cap_dis", cap_dis, m_dis);
      chk(oe_eff === m_oe, "R10", "oe_eff", oe_eff, m_oe);
      chk(pin_out === (steer & m_oe & cmp_out), "R11", "pin_out", pin_out,
          steer & m_oe & cmp_out);
      chk(pin_own === steer, "R11", "pin_own", pin_own, steer);
      if (cap_evt === 1'b1) cap_seen++;
      if (aux_out === 1'b1) aux_seen++;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_src(int s);
    src_in[s] = 1; tick(1); src_in[s] = 0; tick(2);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(0, "R1", "watchdog expired", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int base;
    int aux0;
    tick(3);
    // R1: reset state
    chk(cap_evt === 0, "R1", "cap_evt in reset", cap_evt, 0);
    chk(aux_out === 0, "R1", "aux_out in reset", aux_out, 0);
    chk(oe_eff === 0, "R1", "oe_eff in reset", oe_eff, 0);
    chk(cap_dis === 0, "R1", "cap_dis in reset", cap_dis, 0);
    chk(pin_out === 0, "R1", "pin_out in reset", pin_out, 0);
    rst_n = 1;
    tick(1);
    chk(oe_eff === 0 && cap_evt === 0, "R1", "outputs after release", oe_eff, 0);

    // R2: every source code reaches the capture path
    gate_in = 1; tick(2);
    base = cap_seen;
    for (int s = 0; s < 8; s++) begin
      src_sel = 3'(s); tick(1); pulse_src(s);
    end
    chk(cap_seen - base == 8, "R2", "events over all selects", cap_seen - base, 8);
    src_sel = 0; base = cap_seen;
    pulse_src(5); pulse_src(3);
    chk(cap_seen - base == 0, "R2", "unselected source", cap_seen - base, 0);

    // R3: level mode
    gate_in = 0; tick(2); base = cap_seen;
    pulse_src(0);
    chk(cap_seen - base == 0, "R3", "low gate blocks", cap_seen - base, 0);
    gate_in = 1; tick(2); base = cap_seen;
    pulse_src(0);
    chk(cap_seen - base == 1, "R3", "high gate passes", cap_seen - base, 1);

    // R4: arm on rising gate edge
    gate_mode = 2'b01;
    dis_wr = 1; dis_wdata = 1; tick(1); dis_wr = 0; tick(1);
    base = cap_seen; pulse_src(0);
    chk(cap_seen - base == 0, "R4", "disabled before arm", cap_seen - base, 0);
    gate_in = 0; tick(2); gate_in = 1; tick(2);
    chk(cap_dis === 0, "R4", "cap_dis after rise", cap_dis, 0);
    base = cap_seen; pulse_src(0);
    chk(cap_seen - base == 1, "R4", "armed capture", cap_seen - base, 1);
    gate_in = 0; tick(2); base = cap_seen; pulse_src(0);
    chk(cap_seen - base == 1, "R4", "fall ignored", cap_seen - base, 1);

    // R5: disarm on falling gate edge, sticky, software priority
    gate_mode = 2'b10;
    gate_in = 1; tick(2); gate_in = 0; tick(2);
    chk(cap_dis === 1, "R5", "cap_dis after fall", cap_dis, 1);
    base = cap_seen; pulse_src(0);
    gate_in = 1; tick(2); pulse_src(0);
    chk(cap_seen - base == 0, "R5", "blocked while disabled", cap_seen - base, 0);
    dis_wr = 1; dis_wdata = 0; tick(1); dis_wr = 0; tick(1);
    base = cap_seen; pulse_src(0);
    chk(cap_seen - base == 1, "R5", "software re-enable", cap_seen - base, 1);
    gate_in = 0; dis_wr = 1; dis_wdata = 0; tick(1); dis_wr = 0; tick(1);
    chk(cap_dis === 0, "R5", "write beats fall", cap_dis, 0);

    // R6: reserved code
    gate_mode = 2'b11; gate_in = 1; tick(2); base = cap_seen;
    pulse_src(0); pulse_src(0);
    chk(cap_seen - base == 0, "R6", "reserved blocks", cap_seen - base, 0);

    // R7: rollover and disabled aux
    aux_sel = 2'b01; aux0 = aux_seen;
    for (int k = 0; k < 3; k++) begin tbase_roll = 1; tick(1); tbase_roll = 0; tick(1); end
    tick(1);
    chk(aux_seen - aux0 == 3, "R7", "rollover pulses", aux_seen - aux0, 3);
    aux_sel = 2'b00; aux0 = aux_seen;
    tbase_roll = 1; tick(1); tbase_roll = 0; tick(2);
    chk(aux_seen - aux0 == 0, "R7", "aux disabled", aux_seen - aux0, 0);

    // R8: mode signal and event selection
    aux_sel = 2'b10; aux0 = aux_seen;
    mode_sig = 1; tick(2); mode_sig = 0; tick(2);
    chk(aux_seen - aux0 == 2, "R8", "mode signal", aux_seen - aux0, 2);
    aux_sel = 2'b11; gate_mode = 2'b00; gate_in = 1; tick(2); aux0 = aux_seen;
    cmp_evt = 1; tick(1); cmp_evt = 0; tick(2); pulse_src(0);
    chk(aux_seen - aux0 == 2, "R8", "event pulses", aux_seen - aux0, 2);
    timer_mode = 1; aux0 = aux_seen;
    cmp_evt = 1; tick(1); cmp_evt = 0; tick(2); pulse_src(0);
    chk(aux_seen - aux0 == 0, "R8", "timer mode silent", aux_seen - aux0, 0);
    timer_mode = 0; aux_sel = 2'b00;

    // R9: immediate output enable
    oe_sync = 0; oe_wr = 1; oe_wdata = 1; tick(1); oe_wr = 0;
    chk(oe_eff === 1, "R9", "immediate write", oe_eff, 1);
    oe_wr = 1; oe_wdata = 0; tick(1); oe_wr = 0;
    chk(oe_eff === 0, "R9", "immediate clear", oe_eff, 0);

    // R10: deferred output enable
    oe_sync = 1; oe_wr = 1; oe_wdata = 1; tick(1); oe_wr = 0; tick(3);
    chk(oe_eff === 0, "R10", "held until boundary", oe_eff, 0);
    tbase_roll = 1; tick(1); tbase_roll = 0;
    chk(oe_eff === 1, "R10", "applied on rollover", oe_eff, 1);
    oe_wr = 1; oe_wdata = 0; tick(1); oe_wdata = 1; tick(1); oe_wr = 0; tick(1);
    tbase_roll = 1; tick(1); tbase_roll = 0;
    chk(oe_eff === 1, "R10", "later write replaces", oe_eff, 1);
    oe_wr = 1; oe_wdata = 0; tick(1); oe_wr = 0; tick(2);
    tbase_rst = 1; tick(1); tbase_rst = 0;
    chk(oe_eff === 0, "R10", "applied on time-base reset", oe_eff, 0);
    oe_wr = 1; oe_wdata = 1; tbase_roll = 1; tick(1); oe_wr = 0; tbase_roll = 0;
    chk(oe_eff === 1, "R10", "write on boundary", oe_eff, 1);

    // R11: pin steering
    steer = 1; cmp_out = 1; #1;
    chk(pin_out === 1 && pin_own === 1, "R11", "owned pin drives", pin_out, 1);
    steer = 0; #1;
    chk(pin_out === 0 && pin_own === 0, "R11", "released pin", pin_out, 0);
    tick(1);

    // Random stretch checked against the cycle model.
    for (int i = 0; i < 600; i++) begin
      src_in = 8'($urandom); src_sel = 3'($urandom);
      gate_in = 1'($urandom); gate_mode = 2'($urandom);
      dis_wr = ($urandom % 8) == 0; dis_wdata = 1'($urandom);
      aux_sel = 2'($urandom); tbase_roll = ($urandom % 6) == 0;
      tbase_rst = ($urandom % 9) == 0; cmp_evt = 1'($urandom);
      mode_sig = 1'($urandom); timer_mode = ($urandom % 4) == 0;
      oe_sync = 1'($urandom); oe_wr = ($urandom % 4) == 0; oe_wdata = 1'($urandom);
      steer = 1'($urandom); cmp_out = 1'($urandom);
      tick(1);
    end
    tick(2);
    done = 1;
    summary();
    $finish;
  end
endmodule